// File: doc/BRIEF.md
# Read-Side-Effect Register Block

A control/status register block on a 32-bit AHB-Lite slave port. It holds one word with four 8-bit fields, one per byte lane. When software reads a field, the field changes its stored value. Fields in lanes 0 and 1 drop to 0x00 once read. Fields in lanes 2 and 3 rise to 0xFF once read. The read itself still returns the value the field held before the read took effect.

Hardware updates each field through a one-cycle write strobe and an 8-bit data input. A software read and a hardware write can land on the same field in the same cycle. A fixed per-lane precedence settles that collision:

- Lanes 0 and 2 let the read side-effect win.
- Lanes 1 and 3 let the hardware value win.

Field storage has its own active-low reset, separate from the bus reset. Software writes are accepted with no effect, and the block never stalls or reports an error.

Top module: `rdfx_regblock`

## Requirements
- R1: While `fld_rst_ni` is low, the fields take their reset values: lanes 0 and 1 hold 0xFF, and lanes 2 and 3 hold 0x00. This reads on `fld_q_o` as 0x0000FFFF.
- R2: Each field appears on its own byte lane of `hrdata_o`, with field N on bits 8N+7:8N.
  - In the data phase of a read, every selected lane shows its field's value from before the read. Unselected lanes read 0.
  - Outside a read data phase, `hrdata_o` is 0.
- R3: At the clock edge that ends the read data phase, each selected field changes. Lanes 0 and 1 become 0x00, and lanes 2 and 3 become 0xFF. A second read therefore returns those values.
- R4: Lane selection follows HSIZE and HADDR[1:0].
  - HSIZE=0 (byte) selects lane HADDR[1:0].
  - HSIZE=1 (halfword) selects lanes 1:0 when HADDR[1]=0, and lanes 3:2 when HADDR[1]=1.
  - HSIZE=2 (word) selects all four lanes.
  - Only selected fields take the side-effect.
- R5: When `hw_we_i[N]` is high at a clock edge with no read side-effect on lane N, field N loads `hw_d_i[8N+7:8N]`.
- R6: On lanes 0 and 2 (software precedence), a read side-effect and a hardware write at the same edge leave the field cleared or set. The read still returns the old value.
- R7: On lanes 1 and 3 (hardware precedence), a read side-effect and a hardware write at the same edge leave the field holding the hardware value. The read still returns the old value.
- R8: The following produce no side-effect and no read data:
  - an address phase with HTRANS IDLE (00) or BUSY (01)
  - HSEL low
  - HREADY low
  - HWRITE high
  - HADDR[ADDR_W-1:2] not zero
- R9: `rst_ni` resets only the bus pipeline and leaves field values unchanged. `fld_rst_ni` alone restores the R1 values.
- R10: `hreadyout_o` is always 1 and `hresp_o` is always 0 (OKAY).

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Active-low async bus reset |
| fld_rst_ni | input | 1 | Active-low async field storage reset |
| hsel_i | input | 1 | Slave select |
| haddr_i | input | ADDR_W | Byte address |
| htrans_i | input | 2 | Transfer type |
| hwrite_i | input | 1 | Write when high |
| hsize_i | input | 3 | Transfer size |
| hready_i | input | 1 | Bus ready in |
| hrdata_o | output | 32 | Read data |
| hreadyout_o | output | 1 | Slave ready, always high |
| hresp_o | output | 1 | Response, always OKAY |
| hw_we_i | input | 4 | Per-field hardware write strobe |
| hw_d_i | input | 32 | Hardware write data, field N on bits 8N+7:8N |
| fld_q_o | output | 32 | Current field values, field N on bits 8N+7:8N |

## Verification
Word reads are issued first on the reset value and then on the already-affected value. The pair shows that the old value is returned before the clear or set takes effect.

Byte reads on each address, and halfword reads on both halves, separate lane selection from lane placement. They show whether a side-effect leaks into a neighbouring field.

A word read with all four hardware strobes high in its data phase tells the two precedence settings apart lane by lane. Idle, busy, deselected, not-ready, write and out-of-range transfers, interleaved with the two resets, confirm that field state moves only on a genuine read.

// File: rtl/rdfx_pkg.sv
package rdfx_pkg;
  localparam int unsigned FLD_W   = 8;
  localparam int unsigned NUM_FLD = 4;
  localparam int unsigned BUS_W   = FLD_W * NUM_FLD;

  typedef enum logic {SE_CLEAR = 1'b0, SE_SET = 1'b1} se_kind_e;
  typedef enum logic {PREC_SW = 1'b0, PREC_HW = 1'b1} prec_e;

  localparam logic [1:0] HTRANS_NONSEQ = 2'b10;
  localparam logic [1:0] HTRANS_SEQ    = 2'b11;

  // byte lanes touched by a transfer of given size at given low address
  function automatic logic [NUM_FLD-1:0] lane_mask(logic [2:0] size, logic [1:0] lo);
    logic [NUM_FLD-1:0] m;
    case (size)
      3'd0:    m = NUM_FLD'(1) << lo;
      3'd1:    m = lo[1] ? 4'b1100 : 4'b0011;
      default: m = '1;
    endcase
    return m;
  endfunction

  function automatic se_kind_e kind_of(int unsigned idx);
    return (idx < NUM_FLD/2) ? SE_CLEAR : SE_SET;
  endfunction

  function automatic prec_e prec_of(int unsigned idx);
    return (idx % 2 == 1) ? PREC_HW : PREC_SW;
  endfunction
endpackage

// File: rtl/rdfx_ahb_front.sv
module rdfx_ahb_front
  import rdfx_pkg::*;
#(
  parameter int unsigned ADDR_W = 12
) (
  input  logic               clk_i,
  input  logic               rst_ni,
  input  logic               hsel_i,
  input  logic [ADDR_W-1:0]  haddr_i,
  input  logic [1:0]         htrans_i,
  input  logic               hwrite_i,
  input  logic [2:0]         hsize_i,
  input  logic               hready_i,
  output logic [NUM_FLD-1:0] rd_lanes_o
);
  logic               addr_hit;
  logic               rd_req;
  logic [NUM_FLD-1:0] lanes_d, lanes_q;

  assign addr_hit = (haddr_i[ADDR_W-1:2] == '0);
  assign rd_req   = hsel_i && hready_i && !hwrite_i && addr_hit &&
                    (htrans_i == HTRANS_NONSEQ || htrans_i == HTRANS_SEQ);
  assign lanes_d  = rd_req ? lane_mask(hsize_i, haddr_i[1:0]) : '0;

  // address phase captured; nonzero mask marks a read data phase
  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) lanes_q <= '0;
    else         lanes_q <= lanes_d;
  end

  assign rd_lanes_o = lanes_q;
endmodule

// File: rtl/rdfx_field.sv
module rdfx_field
  import rdfx_pkg::*;
#(
  parameter se_kind_e KIND = SE_CLEAR,
  parameter prec_e    PREC = PREC_SW
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             se_i,
  input  logic             hw_we_i,
  input  logic [FLD_W-1:0] hw_d_i,
  output logic [FLD_W-1:0] q_o
);
  localparam logic [FLD_W-1:0] FILL  = (KIND == SE_SET) ? '1 : '0;
  localparam logic [FLD_W-1:0] RST_V = ~FILL;

  logic [FLD_W-1:0] q, d;

  always_comb begin
    d = q;
    if (se_i && hw_we_i) d = (PREC == PREC_HW) ? hw_d_i : FILL;
    else if (se_i)       d = FILL;
    else if (hw_we_i)    d = hw_d_i;
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) q <= RST_V;
    else         q <= d;
  end

  assign q_o = q;
endmodule

// File: rtl/rdfx_rdata_mux.sv
module rdfx_rdata_mux
  import rdfx_pkg::*;
(
  input  logic [NUM_FLD-1:0] lanes_i,
  input  logic [BUS_W-1:0]   fld_i,
  output logic [BUS_W-1:0]   rdata_o
);
  for (genvar i = 0; i < NUM_FLD; i++) begin : g_lane
    assign rdata_o[i*FLD_W +: FLD_W] = lanes_i[i] ? fld_i[i*FLD_W +: FLD_W] : '0;
  end
endmodule

// File: rtl/rdfx_regblock.sv
module rdfx_regblock
  import rdfx_pkg::*;
#(
  parameter int unsigned ADDR_W = 12
) (
  input  logic                 clk_i,
  input  logic                 rst_ni,
  input  logic                 fld_rst_ni,
  input  logic                 hsel_i,
  input  logic [ADDR_W-1:0]    haddr_i,
  input  logic [1:0]           htrans_i,
  input  logic                 hwrite_i,
  input  logic [2:0]           hsize_i,
  input  logic                 hready_i,
  output logic [31:0]          hrdata_o,
  output logic                 hreadyout_o,
  output logic                 hresp_o,
  input  logic [3:0]           hw_we_i,
  input  logic [31:0]          hw_d_i,
  output logic [31:0]          fld_q_o
);
  logic [NUM_FLD-1:0] rd_lanes;
  logic [BUS_W-1:0]   fld_q;

  rdfx_ahb_front #(.ADDR_W(ADDR_W)) u_front (
    .clk_i      (clk_i),
    .rst_ni     (rst_ni),
    .hsel_i     (hsel_i),
    .haddr_i    (haddr_i),
    .htrans_i   (htrans_i),
    .hwrite_i   (hwrite_i),
    .hsize_i    (hsize_i),
    .hready_i   (hready_i),
    .rd_lanes_o (rd_lanes)
  );

  for (genvar i = 0; i < NUM_FLD; i++) begin : g_fld
    rdfx_field #(.KIND(kind_of(i)), .PREC(prec_of(i))) u_field (
      .clk_i   (clk_i),
      .rst_ni  (fld_rst_ni),
      .se_i    (rd_lanes[i]),
      .hw_we_i (hw_we_i[i]),
      .hw_d_i  (hw_d_i[i*FLD_W +: FLD_W]),
      .q_o     (fld_q[i*FLD_W +: FLD_W])
    );
  end

  rdfx_rdata_mux u_mux (
    .lanes_i (rd_lanes),
    .fld_i   (fld_q),
    .rdata_o (hrdata_o)
  );

  assign hreadyout_o = 1'b1;
  assign hresp_o     = 1'b0;
  assign fld_q_o     = fld_q;
endmodule

// File: rtl/rdfx_regblock_chk.sv
module rdfx_regblock_chk #(
  parameter int unsigned ADDR_W = 12
) (
  input logic              clk_i,
  input logic              rst_ni,
  input logic              fld_rst_ni,
  input logic              hsel_i,
  input logic [ADDR_W-1:0] haddr_i,
  input logic [1:0]        htrans_i,
  input logic              hwrite_i,
  input logic [2:0]        hsize_i,
  input logic              hready_i,
  input logic [3:0]        rd_lanes,
  input logic [3:0]        hw_we_i,
  input logic [31:0]       hw_d_i,
  input logic [31:0]       fld_q_o,
  input logic [31:0]       hrdata_o
);
  p_rdclr_sw_r6: assert property (@(posedge clk_i) disable iff (!rst_ni || !fld_rst_ni)
    rd_lanes[0] |=> fld_q_o[7:0] == 8'h00);
  p_rdset_sw_r6: assert property (@(posedge clk_i) disable iff (!rst_ni || !fld_rst_ni)
    rd_lanes[2] |=> fld_q_o[23:16] == 8'hFF);
  p_hw_win1_r7: assert property (@(posedge clk_i) disable iff (!rst_ni || !fld_rst_ni)
    rd_lanes[1] && hw_we_i[1] |=> fld_q_o[15:8] == $past(hw_d_i[15:8]));
  p_hw_win3_r7: assert property (@(posedge clk_i) disable iff (!rst_ni || !fld_rst_ni)
    rd_lanes[3] && hw_we_i[3] |=> fld_q_o[31:24] == $past(hw_d_i[31:24]));
  p_hw_load_r5: assert property (@(posedge clk_i) disable iff (!rst_ni || !fld_rst_ni)
    hw_we_i[0] && !rd_lanes[0] |=> fld_q_o[7:0] == $past(hw_d_i[7:0]));
  p_hold_r8: assert property (@(posedge clk_i) disable iff (!rst_ni || !fld_rst_ni)
    !rd_lanes[1] && !hw_we_i[1] |=> $stable(fld_q_o[15:8]));
  p_byte_lane_r4: assert property (@(posedge clk_i) disable iff (!rst_ni || !fld_rst_ni)
    hsel_i && hready_i && htrans_i[1] && !hwrite_i && hsize_i == 3'd0 &&
    haddr_i[ADDR_W-1:2] == '0 |=> $countones(rd_lanes) == 1);
  p_idle_r8: assert property (@(posedge clk_i) disable iff (!rst_ni || !fld_rst_ni)
    !(hsel_i && hready_i) |=> rd_lanes == 4'b0);
  p_rdata_zero_r2: assert property (@(posedge clk_i) disable iff (!rst_ni || !fld_rst_ni)
    rd_lanes == 4'b0 |-> hrdata_o == 32'h0);
endmodule

bind rdfx_regblock rdfx_regblock_chk #(.ADDR_W(ADDR_W)) u_chk (
  .clk_i      (clk_i),
  .rst_ni     (rst_ni),
  .fld_rst_ni (fld_rst_ni),
  .hsel_i     (hsel_i),
  .haddr_i    (haddr_i),
  .htrans_i   (htrans_i),
  .hwrite_i   (hwrite_i),
  .hsize_i    (hsize_i),
  .hready_i   (hready_i),
  .rd_lanes   (rd_lanes),
  .hw_we_i    (hw_we_i),
  .hw_d_i     (hw_d_i),
  .fld_q_o    (fld_q_o),
  .hrdata_o   (hrdata_o)
);

// File: tb/rdfx_regblock_tb.sv
`timescale 1ns/1ps
module rdfx_regblock_tb;
  localparam int unsigned ADDR_W = 12;

  logic              clk = 1'b0;
  logic              rst_n = 1'b0;
  logic              fld_rst_n = 1'b0;
  logic              hsel = 1'b0;
  logic [ADDR_W-1:0] haddr = '0;
  logic [1:0]        htrans = 2'b00;
  logic              hwrite = 1'b0;
  logic [2:0]        hsize = 3'd0;
  logic              hready = 1'b1;
  logic [31:0]       hrdata;
  logic              hreadyout, hresp;
  logic [3:0]        hw_we = '0;
  logic [31:0]       hw_d = '0;
  logic [31:0]       fld_q;

  int checks = 0;
  int fails = 0;
  bit done = 0;
  logic [31:0] model;

  always #2.5 clk = ~clk;

  rdfx_regblock #(.ADDR_W(ADDR_W)) u_dut (
    .clk_i(clk), .rst_ni(rst_n), .fld_rst_ni(fld_rst_n),
    .hsel_i(hsel), .haddr_i(haddr), .htrans_i(htrans), .hwrite_i(hwrite),
    .hsize_i(hsize), .hready_i(hready), .hrdata_o(hrdata),
    .hreadyout_o(hreadyout), .hresp_o(hresp),
    .hw_we_i(hw_we), .hw_d_i(hw_d), .fld_q_o(fld_q)
  );

  task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s actual=%08h expected=%08h", req, act, exp);
    end
  endtask

  function automatic logic [3:0] lanes_of(input logic [2:0] sz, input logic [1:0] lo);
    if (sz == 3'd0) return 4'b0001 << lo;
    if (sz == 3'd1) return lo[1] ? 4'b1100 : 4'b0011;
    return 4'b1111;
  endfunction

  function automatic logic [31:0] mask32(input logic [3:0] l);
    logic [31:0] m;
    for (int i = 0; i < 4; i++) m[i*8 +: 8] = l[i] ? 8'hFF : 8'h00;
    return m;
  endfunction

  // expected field update after one edge
  function automatic logic [31:0] next_model(input logic [31:0] cur, input logic [3:0] se,
                                             input logic [3:0] we, input logic [31:0] d);
    logic [31:0] n;
    n = cur;
    for (int i = 0; i < 4; i++) begin
      logic [7:0] fill;
      fill = (i < 2) ? 8'h00 : 8'hFF;
      if (se[i] && we[i])  n[i*8 +: 8] = (i % 2 == 1) ? d[i*8 +: 8] : fill;
      else if (se[i])      n[i*8 +: 8] = fill;
      else if (we[i])      n[i*8 +: 8] = d[i*8 +: 8];
    end
    return n;
  endfunction

  // generic transfer: address phase, then data phase with optional hw strobes
  task automatic xfer(input logic hs, input logic [ADDR_W-1:0] a, input logic [1:0] tr,
                      input logic wr, input logic [2:0] sz, input logic rdy,
                      input logic [3:0] we, input logic [31:0] d,
                      output logic [31:0] rd);
    @(negedge clk);
    hsel = hs; haddr = a; htrans = tr; hwrite = wr; hsize = sz; hready = rdy;
    @(negedge clk);
    hsel = 1'b0; htrans = 2'b00; hwrite = 1'b0; hready = 1'b1;
    hw_we = we; hw_d = d;
    rd = hrdata;
    @(negedge clk);
    hw_we = '0;
  endtask

  task automatic do_read(input string req, input logic [ADDR_W-1:0] a, input logic [2:0] sz,
                         input logic [3:0] we, input logic [31:0] d);
    logic [31:0] rd;
    logic [3:0]  l;
    l = lanes_of(sz, a[1:0]);
    xfer(1'b1, a, 2'b10, 1'b0, sz, 1'b1, we, d, rd);
    chk({req, " rdata"}, rd, model & mask32(l));
    model = next_model(model, l, we, d);
    chk({req, " fields"}, fld_q, model);
  endtask

  task automatic field_reset();
    @(negedge clk); fld_rst_n = 1'b0;
    @(negedge clk); fld_rst_n = 1'b1;
    model = 32'h0000FFFF;
  endtask

  task automatic t_reset();
    @(negedge clk);
    chk("R1 reset fields", fld_q, 32'h0000FFFF);
    chk("R2 idle rdata", hrdata, 32'h0);
    chk("R10 ready/resp", {30'h0, hreadyout, hresp}, 32'h2);
  endtask

  task automatic t_word_reads();
    do_read("R3 word read 1", 12'h000, 3'd2, 4'h0, 32'h0);
    do_read("R3 word read 2", 12'h000, 3'd2, 4'h0, 32'h0);
    chk("R3 settled", fld_q, 32'hFFFF0000);
    field_reset();
  endtask

  task automatic t_byte_reads();
    for (int n = 0; n < 4; n++) begin
      do_read("R4 byte read", 12'(n), 3'd0, 4'h0, 32'h0);
      do_read("R2 byte reread", 12'(n), 3'd0, 4'h0, 32'h0);
    end
    field_reset();
  endtask

  task automatic t_half_reads();
    do_read("R4 half hi", 12'h002, 3'd1, 4'h0, 32'h0);
    chk("R4 half hi low lanes kept", fld_q & 32'h0000FFFF, 32'h0000FFFF);
    do_read("R4 half lo", 12'h000, 3'd1, 4'h0, 32'h0);
    field_reset();
  endtask

  task automatic t_hw_write();
    @(negedge clk); hw_we = 4'hF; hw_d = 32'hA5C3_5A3C;
    @(negedge clk); hw_we = 4'h0;
    model = 32'hA5C3_5A3C;
    chk("R5 hw write all", fld_q, model);
    @(negedge clk); hw_we = 4'b0100; hw_d = 32'h0077_0000;
    @(negedge clk); hw_we = 4'h0;
    model = 32'hA577_5A3C;
    chk("R5 hw write lane2", fld_q, model);
    do_read("R2 read after hw", 12'h000, 3'd2, 4'h0, 32'h0);
    field_reset();
  endtask

  task automatic t_collision();
    do_read("R6 R7 collision word", 12'h000, 3'd2, 4'hF, 32'h4433_2211);
    chk("R6 R7 collision result", fld_q, 32'h44FF_2200);
    field_reset();
    do_read("R7 collision byte1", 12'h001, 3'd0, 4'b0010, 32'h0000_5500);
    chk("R7 byte1 hw wins", fld_q, 32'h0000_55FF);
    do_read("R6 collision byte2", 12'h002, 3'd0, 4'b0100, 32'h0066_0000);
    chk("R6 byte2 set wins", fld_q, 32'h00FF_55FF);
    field_reset();
  endtask

  task automatic t_ignored();
    logic [31:0] rd;
    xfer(1'b1, 12'h000, 2'b00, 1'b0, 3'd2, 1'b1, 4'h0, 32'h0, rd);
    chk("R8 idle rdata", rd, 32'h0); chk("R8 idle fields", fld_q, model);
    xfer(1'b1, 12'h000, 2'b01, 1'b0, 3'd2, 1'b1, 4'h0, 32'h0, rd);
    chk("R8 busy rdata", rd, 32'h0); chk("R8 busy fields", fld_q, model);
    xfer(1'b0, 12'h000, 2'b10, 1'b0, 3'd2, 1'b1, 4'h0, 32'h0, rd);
    chk("R8 unselected rdata", rd, 32'h0); chk("R8 unselected fields", fld_q, model);
    xfer(1'b1, 12'h000, 2'b10, 1'b0, 3'd2, 1'b0, 4'h0, 32'h0, rd);
    chk("R8 not ready rdata", rd, 32'h0); chk("R8 not ready fields", fld_q, model);
    xfer(1'b1, 12'h000, 2'b10, 1'b1, 3'd2, 1'b1, 4'h0, 32'h0, rd);
    chk("R8 write rdata", rd, 32'h0); chk("R8 write fields", fld_q, model);
    xfer(1'b1, 12'h004, 2'b10, 1'b0, 3'd2, 1'b1, 4'h0, 32'h0, rd);
    chk("R8 out of range rdata", rd, 32'h0); chk("R8 out of range fields", fld_q, model);
    do_read("R8 seq read counts", 12'h000, 3'd2, 4'h0, 32'h0);
    field_reset();
  endtask

  task automatic t_resets();
    @(negedge clk); hw_we = 4'hF; hw_d = 32'h1234_5678;
    @(negedge clk); hw_we = 4'h0;
    @(negedge clk); rst_n = 1'b0;
    @(negedge clk); rst_n = 1'b1;
    chk("R9 bus reset keeps fields", fld_q, 32'h1234_5678);
    chk("R10 ready/resp after bus reset", {30'h0, hreadyout, hresp}, 32'h2);
    field_reset();
    chk("R9 field reset restores", fld_q, 32'h0000FFFF);
  endtask

  initial begin
    model = 32'h0000FFFF;
    repeat (3) @(negedge clk);
    rst_n = 1'b1; fld_rst_n = 1'b1;
    t_reset();
    t_word_reads();
    t_byte_reads();
    t_half_reads();
    t_hw_write();
    t_collision();
    t_ignored();
    t_resets();
    if (!done) begin
      done = 1;
      $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
      $finish;
    end
  end

  initial begin
    #(5.0 * 100000);
    if (!done) begin
      done = 1;
      checks++; fails++;
      $display("FAIL watchdog actual=%08h expected=%08h", 32'h1, 32'h0);
      $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
      $finish;
    end
  end
endmodule